// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits between the sample data path of a converter and its parallel output bus. In normal operation it forwards each sample to the output, registered once. When a test code is written, it replaces the samples with a known word. This lets the bus and the receiving logic be checked in place, without an analog input.

A byte-wide register port writes the configuration. One control register holds a 4-bit pattern code and a 2-bit presentation field. Four byte registers hold two 16-bit user words. The available patterns are midscale, positive full scale, negative full scale, checkerboard, one/zero and the user pair. A paired pattern can be held at its first word, or its two words can alternate on successive sample clocks. The output carries the top bits of the selected 16-bit word.

The register port runs on its own clock. Any accepted write flips a toggle. That toggle is synchronized into the sample clock domain, and on the next edge the complete configuration is captured in one sample clock. A new setting therefore reaches the output a few sample clocks after the write.

Top module: `adc_tpg`

## Requirements
- R1: While rst_ni is low, data_o is 0 and the configuration is cleared to code 0 with the static presentation, so the first cycles after reset pass sample data through.
- R2: With pattern code 0, data_o equals the smp_data_i value presented one sample clock earlier.
- R3: Codes 1, 2 and 3 output the top OUT_W bits of 0x8000, 0xFFFF and 0x0000 respectively, constant on every sample clock.
- R4: Code 4 (word pair 0xAAAA / 0x5555) and code 7 (word pair 0xFFFF / 0x0000) follow the presentation field in control bits [7:6]. With 01, the two words alternate on successive sample clocks. With 00, only the first word is output.
- R5: Code 8 outputs the user pair. The first user word is written low byte at address 0x02 and high byte at 0x03. The second user word is written low byte at 0x04 and high byte at 0x05. It obeys the presentation field like R4.
- R6: Codes 1, 2 and 3 stay static even when the presentation field is 01.
- R7: Codes 5, 6 and 9 to 15 pass sample data through as code 0 does. Presentation values 10 and 11 behave as static.
- R8: The control register is at address 0x00, with the code in bits [3:0] and the presentation in bits [7:6]. Writes to any address other than 0x00 and 0x02 to 0x05 change nothing.
- R9: A write reaches data_o no sooner than SYNC_STAGES sample clocks after it is accepted. The control fields and both user words are applied together in a single sample clock, and never between write events.
- R10: Each time a configuration is applied, an alternating pattern restarts with its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk_i | input | 1 | Sample clock |
| cfg_clk_i | input | 1 | Register port clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| smp_data_i | input | OUT_W | Converter sample data |
| data_o | output | OUT_W | Output bus word |

## Verification
The bench uses the default parameters: OUT_W of 10, ADDR_W of 8 and SYNC_STAGES of 2. The register clock runs at 100 MHz against the 250 MHz sample clock. At these settings the 10-bit truncation of every fixed word is observable, and the user words are chosen so that the low six bits that are dropped differ from the upper bits that are kept. A two-stage synchronizer keeps the crossing latency short enough that the bench can poll, cycle by cycle, for the first pattern word after a mode change. That polling also measures the minimum latency.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int PAT_W = 16;

  localparam int ADR_CTRL  = 'h00;
  localparam int ADR_P1_LO = 'h02;
  localparam int ADR_P1_HI = 'h03;
  localparam int ADR_P2_LO = 'h04;
  localparam int ADR_P2_HI = 'h05;

  localparam logic [1:0] PRES_ALT = 2'b01;

  typedef enum logic [3:0] {
    PC_OFF  = 4'd0,
    PC_MID  = 4'd1,
    PC_PFS  = 4'd2,
    PC_NFS  = 4'd3,
    PC_CHK  = 4'd4,
    PC_ONEZ = 4'd7,
    PC_USER = 4'd8
  } pat_code_e;

  typedef struct packed {
    logic [1:0]       pres;
    logic [3:0]       code;
    logic [PAT_W-1:0] usr1;
    logic [PAT_W-1:0] usr2;
  } cfg_t;

  function automatic logic code_active(logic [3:0] c);
    case (c)
      PC_MID, PC_PFS, PC_NFS, PC_CHK, PC_ONEZ, PC_USER: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic code_paired(logic [3:0] c);
    return (c == PC_CHK) || (c == PC_ONEZ) || (c == PC_USER);
  endfunction
endpackage

// File: rtl/tpg_cfg_regs.sv
module tpg_cfg_regs
  import tpg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              cfg_clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output cfg_t              cfg_o,
  output logic              tog_o
);
  cfg_t cfg_q;
  logic tog_q;
  logic hit;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i[5:4];

  always_comb begin
    hit = 1'b0;
    if (addr_i == ADDR_W'(ADR_CTRL)  || addr_i == ADDR_W'(ADR_P1_LO) ||
        addr_i == ADDR_W'(ADR_P1_HI) || addr_i == ADDR_W'(ADR_P2_LO) ||
        addr_i == ADDR_W'(ADR_P2_HI))
      hit = 1'b1;
  end

  always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      tog_q <= 1'b0;
    end else if (we_i && hit) begin
      tog_q <= ~tog_q;
      if (addr_i == ADDR_W'(ADR_CTRL)) begin
        cfg_q.pres <= wdata_i[7:6];
        cfg_q.code <= wdata_i[3:0];
      end
      if (addr_i == ADDR_W'(ADR_P1_LO)) cfg_q.usr1[7:0]        <= wdata_i;
      if (addr_i == ADDR_W'(ADR_P1_HI)) cfg_q.usr1[PAT_W-1:8]  <= wdata_i;
      if (addr_i == ADDR_W'(ADR_P2_LO)) cfg_q.usr2[7:0]        <= wdata_i;
      if (addr_i == ADDR_W'(ADR_P2_HI)) cfg_q.usr2[PAT_W-1:8]  <= wdata_i;
    end
  end

  assign cfg_o = cfg_q;
  assign tog_o = tog_q;
endmodule

// File: rtl/tpg_cdc.sv
module tpg_cdc
  import tpg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic smp_clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  input  logic tog_i,
  output cfg_t cfg_o,
  output logic apply_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic tog_seen_q;
  logic apply_q;
  cfg_t cfg_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge smp_clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else if (i == 0) sync_q[i] <= tog_i;
      else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
    end
  end

  // Source bundle is quiet once the toggle has settled; capture it whole.
  always_ff @(posedge smp_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_seen_q <= 1'b0;
      apply_q    <= 1'b0;
      cfg_q      <= '0;
    end else begin
      tog_seen_q <= sync_q[LAST];
      apply_q    <= sync_q[LAST] ^ tog_seen_q;
      if (apply_q) cfg_q <= cfg_i;
    end
  end

  assign cfg_o   = cfg_q;
  assign apply_o = apply_q;
endmodule

// File: rtl/tpg_gen.sv
module tpg_gen
  import tpg_pkg::*;
#(
  parameter int OUT_W = 10
) (
  input  logic             smp_clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic             apply_i,
  input  logic [OUT_W-1:0] smp_data_i,
  output logic [OUT_W-1:0] data_o
);
  localparam logic [PAT_W-1:0] W_MID  = PAT_W'(1) << (PAT_W-1);
  localparam logic [PAT_W-1:0] W_ONES = '1;
  localparam logic [PAT_W-1:0] W_CHK1 = {(PAT_W/2){2'b10}};

  logic phase_q;
  logic alt;
  logic active;
  logic [PAT_W-1:0] word;
  logic [OUT_W-1:0] data_q;

  assign active = code_active(cfg_i.code);
  assign alt    = (cfg_i.pres == PRES_ALT) && code_paired(cfg_i.code);

  always_comb begin
    case (cfg_i.code)
      PC_MID:  word = W_MID;
      PC_PFS:  word = W_ONES;
      PC_CHK:  word = phase_q ? ~W_CHK1 : W_CHK1;
      PC_ONEZ: word = phase_q ? '0 : W_ONES;
      PC_USER: word = phase_q ? cfg_i.usr2 : cfg_i.usr1;
      default: word = '0;
    endcase
  end

  always_ff @(posedge smp_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (apply_i || !alt) phase_q <= 1'b0;
      else phase_q <= ~phase_q;
      data_q <= active ? word[PAT_W-1 -: OUT_W] : smp_data_i;
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/adc_tpg.sv
module adc_tpg
  import tpg_pkg::*;
#(
  parameter int OUT_W       = 10,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              smp_clk_i,
  input  logic              cfg_clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic [OUT_W-1:0]  smp_data_i,
  output logic [OUT_W-1:0]  data_o
);
  cfg_t cfg_src;
  logic cfg_tog;
  cfg_t cfg_s;
  logic apply_s;

  tpg_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .cfg_clk_i (cfg_clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .cfg_o     (cfg_src),
    .tog_o     (cfg_tog)
  );

  tpg_cdc #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .smp_clk_i (smp_clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg_src),
    .tog_i     (cfg_tog),
    .cfg_o     (cfg_s),
    .apply_o   (apply_s)
  );

  tpg_gen #(.OUT_W(OUT_W)) u_gen (
    .smp_clk_i  (smp_clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg_s),
    .apply_i    (apply_s),
    .smp_data_i (smp_data_i),
    .data_o     (data_o)
  );
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
  import tpg_pkg::*;
#(
  parameter int OUT_W = 10
) (
  input logic             smp_clk_i,
  input logic             rst_ni,
  input logic [OUT_W-1:0] smp_data_i,
  input logic [OUT_W-1:0] data_o,
  input logic             apply_s,
  input cfg_t             cfg_s
);
  function automatic logic [OUT_W-1:0] top_of(logic [PAT_W-1:0] w);
    return w[PAT_W-1 -: OUT_W];
  endfunction

  function automatic logic [PAT_W-1:0] exp_first(cfg_t c);
    case (c.code)
      4'd1:    return 16'h8000;
      4'd2:    return 16'hFFFF;
      4'd4:    return 16'hAAAA;
      4'd7:    return 16'hFFFF;
      4'd8:    return c.usr1;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [PAT_W-1:0] exp_second(cfg_t c);
    case (c.code)
      4'd4:    return 16'h5555;
      4'd8:    return c.usr2;
      default: return 16'h0000;
    endcase
  endfunction

  logic on, alt, differ;
  assign on     = code_active(cfg_s.code);
  assign alt    = on && (cfg_s.pres == 2'b01) && code_paired(cfg_s.code);
  assign differ = top_of(exp_first(cfg_s)) != top_of(exp_second(cfg_s));

  AST_PASS_THRU: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    !on |=> data_o == $past(smp_data_i)); // R2

  AST_STATIC_HOLD: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    ($stable(cfg_s) && on && !alt) |=> $stable(data_o)); // R6

  AST_ALT_TOGGLE: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    ($stable(cfg_s) && alt && differ && !$past(apply_s)) |=> data_o != $past(data_o)); // R4

  AST_APPLY_ATOMIC: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    !apply_s |=> $stable(cfg_s)); // R9

  AST_PHASE_RESTART: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    (apply_s ##1 on) |=> data_o == $past(top_of(exp_first(cfg_s)))); // R10
endmodule

bind adc_tpg tpg_checker #(.OUT_W(OUT_W)) u_chk (
  .smp_clk_i  (smp_clk_i),
  .rst_ni     (rst_ni),
  .smp_data_i (smp_data_i),
  .data_o     (data_o),
  .apply_s    (apply_s),
  .cfg_s      (cfg_s)
);

// File: tb/adc_tpg_bench.sv
module adc_tpg_bench;
  localparam int OUT_W = 10;
  localparam int ADDR_W = 8;
  localparam int SYNC_STAGES = 2;

  logic smp_clk = 1'b0;
  logic cfg_clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [OUT_W-1:0] smp_data = '0;
  logic [OUT_W-1:0] dout;

  int vecs = 0;
  int fails = 0;
  bit done = 0;

  always #2 smp_clk = ~smp_clk;
  always #5 cfg_clk = ~cfg_clk;

  adc_tpg #(.OUT_W(OUT_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_adc_tpg (
    .smp_clk_i (smp_clk), .cfg_clk_i (cfg_clk), .rst_ni (rst_n),
    .cfg_we_i (we), .cfg_addr_i (addr), .cfg_wdata_i (wdata),
    .smp_data_i (smp_data), .data_o (dout)
  );

  function automatic int top(logic [15:0] w);
    return int'(w[15 -: OUT_W]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge cfg_clk);
    we = 1'b1; addr = ADDR_W'(a); wdata = 8'(d);
    @(negedge cfg_clk);
    we = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge smp_clk);
  endtask

  task automatic expect_static(input string req, input int w);
    for (int i = 0; i < 3; i++) begin
      @(negedge smp_clk);
      chk(req, int'(dout), w);
    end
  endtask

  task automatic expect_alt(input string req, input int w1, input int w2);
    int a, b, c;
    @(negedge smp_clk); a = int'(dout);
    @(negedge smp_clk); b = int'(dout);
    @(negedge smp_clk); c = int'(dout);
    chk(req, a, (a == w2) ? w2 : w1);
    chk(req, b, (a == w1) ? w2 : w1);
    chk(req, c, a);
  endtask

  task automatic t_reset();
    @(negedge smp_clk);
    chk("R1 reset out", int'(dout), 0);
    rst_n = 1'b1;
    smp_data = 10'h155;
    @(negedge smp_clk); @(negedge smp_clk);
    chk("R1 post-reset pass", int'(dout), 'h155);
  endtask

  task automatic t_pass();
    int vals[4] = '{'h001, 'h3FE, 'h2C3, 'h000};
    wr('h00, 'h00); settle();
    foreach (vals[i]) begin
      smp_data = 10'(vals[i]);
      @(negedge smp_clk);
      chk("R2 pass-through", int'(dout), vals[i]);
    end
  endtask

  task automatic t_fixed();
    wr('h00, 'h01); settle(); expect_static("R3 midscale", top(16'h8000));
    wr('h00, 'h02); settle(); expect_static("R3 pos full", top(16'hFFFF));
    wr('h00, 'h03); settle(); expect_static("R3 neg full", top(16'h0000));
    wr('h00, 'h41); settle(); expect_static("R6 midscale alt", top(16'h8000));
    wr('h00, 'h42); settle(); expect_static("R6 pos full alt", top(16'hFFFF));
  endtask

  task automatic t_pairs();
    wr('h00, 'h44); settle(); expect_alt("R4 checker alt", top(16'hAAAA), top(16'h5555));
    wr('h00, 'h04); settle(); expect_static("R4 checker static", top(16'hAAAA));
    wr('h00, 'h47); settle(); expect_alt("R4 onezero alt", top(16'hFFFF), top(16'h0000));
    wr('h00, 'h07); settle(); expect_static("R4 onezero static", top(16'hFFFF));
  endtask

  task automatic t_user();
    wr('h02, 'h34); wr('h03, 'h12); wr('h04, 'hDC); wr('h05, 'hFE);
    wr('h00, 'h48); settle(); expect_alt("R5 user alt", top(16'h1234), top(16'hFEDC));
    wr('h00, 'h08); settle(); expect_static("R5 user static", top(16'h1234));
  endtask

  task automatic t_reserved();
    int codes[4] = '{5, 6, 9, 15};
    foreach (codes[i]) begin
      wr('h00, codes[i]); settle();
      smp_data = 10'(('h0A5 + i * 'h33));
      @(negedge smp_clk);
      chk("R7 reserved code pass", int'(dout), int'(smp_data));
    end
    wr('h00, 'h84); settle(); expect_static("R7 pres 10 static", top(16'hAAAA));
    wr('h00, 'hC7); settle(); expect_static("R7 pres 11 static", top(16'hFFFF));
  endtask

  task automatic t_unmapped();
    wr('h00, 'h01); settle();
    wr('h01, 'h44); wr('h06, 'h47); wr('h80, 'h48); settle();
    expect_static("R8 unmapped ignored", top(16'h8000));
  endtask

  task automatic t_restart();
    int n;
    wr('h00, 'h00);
    smp_data = 10'h0F0;
    settle();
    wr('h00, 'h47);
    n = 0;
    while (dout == 10'h0F0 && n < 40) begin
      @(negedge smp_clk);
      n++;
    end
    chk("R9 latency at least sync depth", int'(n >= SYNC_STAGES), 1);
    chk("R10 first word after change", int'(dout), top(16'hFFFF));
    @(negedge smp_clk);
    chk("R10 second word", int'(dout), top(16'h0000));
  endtask

  initial begin
    repeat (100000) @(posedge smp_clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge smp_clk);
    t_reset();
    t_pass();
    t_fixed();
    t_pairs();
    t_user();
    t_reserved();
    t_unmapped();
    t_restart();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule